// File: doc/BRIEF.md
# Cascadable Rotating-Priority Interrupt Controller

The block collects interrupt requests from sixteen level-sensitive device lines and presents one interrupt signal to the CPU. Inside are two identical eight-level controller units. The sub unit takes eight device lines. Its interrupt output is wired into level 2 of the main unit, and the main unit feeds the CPU. Each unit holds a mask register, a request register that samples its inputs every clock, an in-service register and a pointer to the level that currently has the highest priority.

Software reaches either unit through a byte-wide register port. A unit-select bit picks the unit, and a register-select bit picks either the command register or the mask register. An acknowledge strobe returns, in the same cycle, the vector of the highest-priority pending unmasked request and moves that request into service. The vector is the level number: 0 to 7 for the main unit and 8 to 15 for the sub unit. When the main unit picks its cascade level, the vector comes from the sub unit. A specific end-of-interrupt command with rotation retires a level and makes that level the lowest priority.

Top module: `irq_cascade_pair`

## Requirements
- R1: After reset, both mask registers read 0xFF, both request registers read 0x00, no level is in service, level 0 has the highest priority and `int_cpu` is low.
- R2: A write with `bus_reg`=1 replaces all eight mask bits of the selected unit (`bus_sub`=0 main, 1 sub). The same address reads the value back on `bus_rdata`.
- R3: A read with `bus_reg`=0 returns the selected unit's request register, which holds its input lines as sampled at the previous clock edge, whatever the mask.
- R4: A request whose mask bit is 1 never raises `int_cpu` and is never chosen on acknowledge.
- R5: `int_cpu` is high exactly when some unmasked pending request has a strictly higher priority than every in-service level of the main unit. Priority rank is (level − highest-priority level) mod 8.
- R6: While `ack` is high and `int_cpu` is high, `vector` shows, in the same cycle, the base plus the level of the highest-priority unmasked pending request. At the clock edge that level's in-service bit is set.
- R7: Out of reset, level 0 is served first and priority falls with rising level number.
- R8: A command write of 0xE0 OR'd with a 3-bit level n clears in-service bit n, and level n+1 mod 8 becomes the highest priority.
- R9: When level n is not in service, the R8 command leaves the in-service register unchanged but still applies the rotation. Command values whose top five bits are not 11100 change nothing.
- R10: Level 2 of the main unit is driven by the sub unit's interrupt output. When the main unit picks level 2 on acknowledge, `vector` is 8 plus the sub unit's chosen level, and both units set their in-service bits.
- R11: An acknowledge while `int_cpu` is low returns the spurious vector 7 and changes no register.
- R12: `irq_main` bits 1:0 drive main levels 1:0, and `irq_main` bits 6:2 drive main levels 7:3. `irq_sub` bit k drives sub level k, which has vector 8+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_main | input | 7 | Device lines of the main unit, all levels except the cascade level |
| irq_sub | input | 8 | Device lines of the sub unit |
| bus_wr | input | 1 | Register write strobe |
| bus_sub | input | 1 | Unit select: 0 main, 1 sub |
| bus_reg | input | 1 | Register select: 0 command/request, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| int_cpu | output | 1 | Interrupt request to the CPU |
| ack | input | 1 | Acknowledge strobe |
| vector | output | 8 | Vector returned during acknowledge |

## Verification
On every cycle, the assertions check four things. A mask write loads the exact byte. An acknowledged level always lands in service. The rotate command moves the priority pointer to n+1. The in-service register holds when there is neither an acknowledge nor a rotate command. They also check that the interrupt always points at an unmasked pending level and that the cascade vector matches the sub unit's choice. Only the bench scenarios can show the full priority orderings after successive rotations, nested preemption by a higher level, the spurious vector, and the effect of a rotate command on a level that is not in service. They also cover the two end-of-interrupt writes that a cascaded line needs before it can be raised again.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DATA_W = 8;
   localparam logic REG_CMD  = 1'b0;
   localparam logic REG_MASK = 1'b1;
   // rotate-on-specific-EOI opcode, level number in the low bits
   localparam logic [DATA_W-1:0] EOI_ROT_OP = 8'hE0;
endpackage

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
   parameter int LEVEL_W = 3
) (
   input  logic [(1<<LEVEL_W)-1:0] bits_in,
   input  logic [LEVEL_W-1:0]      start,
   output logic                    found,
   output logic [LEVEL_W-1:0]      idx
);
   localparam int N = 1 << LEVEL_W;

   logic [2*N-1:0]     dbl;
   logic [N-1:0]       rot;
   logic [LEVEL_W-1:0] off;

   assign dbl = {bits_in, bits_in};
   assign rot = dbl[start +: N];

   always_comb begin
      off = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i]) off = LEVEL_W'(i);
      end
   end

   assign found = |rot;
   assign idx   = start + off;
endmodule

// File: rtl/irq_unit8.sv
module irq_unit8 import irq_pkg::*; #(
   parameter int LEVEL_W  = 3,
   parameter int VEC_BASE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<LEVEL_W)-1:0] req_in,
   input  logic                    wr_en,
   input  logic                    reg_sel,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   input  logic                    ack,
   output logic                    int_out,
   output logic [LEVEL_W-1:0]      pick_lvl,
   output logic [DATA_W-1:0]       vec_out
);
   localparam int N = 1 << LEVEL_W;

   if (N != DATA_W) begin : g_bad_width
      $error("irq_unit8: level count must equal the data width");
   end
   if (VEC_BASE + N > 256) begin : g_bad_base
      $error("irq_unit8: vector base out of range");
   end

   logic [N-1:0]       mask_q, irr_q, isr_q, pend, clr, set;
   logic [LEVEL_W-1:0] top_q, req_idx, isr_idx, req_rank, isr_rank, eoi_lvl;
   logic               req_found, isr_found, take, eoi_hit;

   assign pend = irr_q & ~mask_q;

   irq_rot_pick #(.LEVEL_W(LEVEL_W)) u_req_pick (
      .bits_in(pend), .start(top_q), .found(req_found), .idx(req_idx));
   irq_rot_pick #(.LEVEL_W(LEVEL_W)) u_isr_pick (
      .bits_in(isr_q), .start(top_q), .found(isr_found), .idx(isr_idx));

   assign req_rank = req_idx - top_q;
   assign isr_rank = isr_idx - top_q;
   assign int_out  = req_found && (!isr_found || (req_rank < isr_rank));
   assign take     = ack && int_out;
   assign pick_lvl = req_idx;
   assign vec_out  = take ? (8'(VEC_BASE) + 8'(req_idx))
                          : (8'(VEC_BASE) + 8'(N - 1));

   assign eoi_hit = wr_en && (reg_sel == REG_CMD)
                    && (wr_data[DATA_W-1:LEVEL_W] == EOI_ROT_OP[DATA_W-1:LEVEL_W]);
   assign eoi_lvl = wr_data[LEVEL_W-1:0];
   assign clr     = eoi_hit ? (N'(1) << eoi_lvl) : '0;
   assign set     = take ? (N'(1) << req_idx) : '0;
   assign rd_data = (reg_sel == REG_MASK) ? mask_q : irr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         irr_q  <= '0;
         isr_q  <= '0;
         top_q  <= '0;
      end else begin
         irr_q <= req_in;
         isr_q <= (isr_q & ~clr) | set;
         if (wr_en && (reg_sel == REG_MASK)) mask_q <= wr_data;
         if (eoi_hit) top_q <= eoi_lvl + LEVEL_W'(1);
      end
   end

   assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_MASK) |=> (mask_q == $past(wr_data)));
   assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (irr_q[req_idx] && !mask_q[req_idx]));
   assert_ack_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> isr_q[$past(req_idx)]);
   assert_eoi_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_hit |=> (top_q == LEVEL_W'($past(eoi_lvl) + LEVEL_W'(1))));
   assert_isr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !eoi_hit) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair import irq_pkg::*; #(
   parameter int LEVEL_W       = 3,
   parameter int CASCADE_LEVEL = 2,
   parameter int MAIN_BASE     = 0,
   parameter int SUB_BASE      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<LEVEL_W)-2:0] irq_main,
   input  logic [(1<<LEVEL_W)-1:0] irq_sub,
   input  logic                    bus_wr,
   input  logic                    bus_sub,
   input  logic                    bus_reg,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   output logic                    int_cpu,
   input  logic                    ack,
   output logic [7:0]              vector
);
   localparam int N = 1 << LEVEL_W;

   if (CASCADE_LEVEL >= N) begin : g_bad_casc
      $error("irq_cascade_pair: cascade level out of range");
   end

   logic [N-1:0]       m_req;
   logic [DATA_W-1:0]  m_rd, s_rd, m_vec, s_vec;
   logic [LEVEL_W-1:0] m_pick, s_pick;
   logic               m_int, s_int, casc_hit, s_ack;

   // main unit inputs: cascade level from sub unit, others from device lines
   for (genvar g = 0; g < N; g++) begin : g_main_in
      if (g == CASCADE_LEVEL) begin : g_casc
         assign m_req[g] = s_int;
      end else if (g < CASCADE_LEVEL) begin : g_low
         assign m_req[g] = irq_main[g];
      end else begin : g_high
         assign m_req[g] = irq_main[g-1];
      end
   end

   irq_unit8 #(.LEVEL_W(LEVEL_W), .VEC_BASE(MAIN_BASE)) u_main (
      .clk(clk), .rst_n(rst_n), .req_in(m_req),
      .wr_en(bus_wr && !bus_sub), .reg_sel(bus_reg), .wr_data(bus_wdata),
      .rd_data(m_rd), .ack(ack), .int_out(m_int), .pick_lvl(m_pick),
      .vec_out(m_vec));

   assign casc_hit = m_int && (m_pick == LEVEL_W'(CASCADE_LEVEL));
   assign s_ack    = ack && casc_hit;

   irq_unit8 #(.LEVEL_W(LEVEL_W), .VEC_BASE(SUB_BASE)) u_sub (
      .clk(clk), .rst_n(rst_n), .req_in(irq_sub),
      .wr_en(bus_wr && bus_sub), .reg_sel(bus_reg), .wr_data(bus_wdata),
      .rd_data(s_rd), .ack(s_ack), .int_out(s_int), .pick_lvl(s_pick),
      .vec_out(s_vec));

   assign int_cpu   = m_int;
   assign vector    = casc_hit ? s_vec : m_vec;
   assign bus_rdata = bus_sub ? s_rd : m_rd;

   assert_casc_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ack && s_int) |-> (vector == 8'(SUB_BASE) + 8'(s_pick)));
   assert_int_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_cpu |-> (m_req != '0));
endmodule

// File: tb/irq_cascade_pair_test.sv
module irq_cascade_pair_test;
   logic       clk = 0, rst_n = 0;
   logic [6:0] irq_main = '0;
   logic [7:0] irq_sub = '0;
   logic       bus_wr = 0, bus_sub = 0, bus_reg = 0, ack = 0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, vector;
   logic       int_cpu;
   int checks = 0, failures = 0;

   always #4 clk = ~clk;

   irq_cascade_pair uut (
      .clk(clk), .rst_n(rst_n), .irq_main(irq_main), .irq_sub(irq_sub),
      .bus_wr(bus_wr), .bus_sub(bus_sub), .bus_reg(bus_reg),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_cpu(int_cpu),
      .ack(ack), .vector(vector));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; irq_main = '0; irq_sub = '0; bus_wr = 0; ack = 0;
      tick(); tick();
      rst_n = 1;
      tick();
   endtask

   task automatic wr(input logic sub, input logic regsel, input logic [7:0] d);
      bus_sub = sub; bus_reg = regsel; bus_wdata = d; bus_wr = 1;
      tick();
      bus_wr = 0;
   endtask

   task automatic rd(input logic sub, input logic regsel, output logic [7:0] d);
      bus_sub = sub; bus_reg = regsel; #1;
      d = bus_rdata;
   endtask

   task automatic take_ack(output logic [7:0] v);
      ack = 1; #1;
      v = vector;
      tick();
      ack = 0; #1;
   endtask

   // main line for level L (L != 2)
   function automatic logic [6:0] mline(input int l);
      return (l < 2) ? 7'(1 << l) : 7'(1 << (l - 1));
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      rd(0, 1, d); chk("R1 main mask", d, 8'hFF);
      rd(1, 1, d); chk("R1 sub mask", d, 8'hFF);
      rd(0, 0, d); chk("R1 main req", d, 8'h00);
      chk("R1 int", int_cpu, 0);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      do_reset();
      wr(0, 1, 8'h5A); rd(0, 1, d); chk("R2 main mask", d, 8'h5A);
      wr(1, 1, 8'h3C); rd(1, 1, d); chk("R2 sub mask", d, 8'h3C);
      rd(0, 1, d); chk("R2 main kept", d, 8'h5A);
   endtask

   task automatic t_reqread();
      logic [7:0] d;
      do_reset();
      irq_main = 7'b1010011; irq_sub = 8'h81;
      tick();
      rd(0, 0, d); chk("R3 R12 main req", d, 8'hA3);
      rd(1, 0, d); chk("R3 sub req", d, 8'h81);
      chk("R4 masked int", int_cpu, 0);
   endtask

   task automatic t_rotate();
      logic [7:0] v;
      do_reset();
      wr(0, 1, 8'h00);
      irq_main = mline(3) | mline(6);
      tick();
      chk("R5 int", int_cpu, 1);
      take_ack(v); chk("R6 R7 vec", v, 3);
      chk("R5 lower blocked", int_cpu, 0);
      irq_main = irq_main | mline(5);
      tick();
      wr(0, 0, 8'hE3);
      chk("R8 int after eoi", int_cpu, 1);
      take_ack(v); chk("R8 rotated vec", v, 5);
      wr(0, 0, 8'hE5);
      take_ack(v); chk("R8 next vec", v, 6);
      wr(0, 0, 8'hE6);
      take_ack(v); chk("R8 wrap vec", v, 3);
      chk("R5 held", int_cpu, 0);
      irq_main = irq_main | mline(0);
      tick();
      chk("R5 nested", int_cpu, 1);
      take_ack(v); chk("R5 nested vec", v, 0);
   endtask

   task automatic t_eoi_idle();
      logic [7:0] v;
      do_reset();
      wr(0, 1, 8'h00);
      wr(0, 0, 8'hE4);
      irq_main = mline(0) | mline(6);
      tick();
      take_ack(v); chk("R9 rotate w/o service", v, 6);
      do_reset();
      wr(0, 1, 8'h00);
      wr(0, 0, 8'hE1);
      irq_main = mline(0) | mline(3);
      tick();
      take_ack(v); chk("R9 vec", v, 3);
      wr(0, 0, 8'hE2);
      chk("R9 isr kept", int_cpu, 0);
   endtask

   task automatic t_badcmd();
      logic [7:0] v;
      do_reset();
      wr(0, 1, 8'h00);
      irq_main = mline(3);
      tick();
      take_ack(v); chk("R6 vec", v, 3);
      wr(0, 0, 8'h20);
      chk("R9 ignored cmd", int_cpu, 0);
      wr(0, 0, 8'hE3);
      chk("R8 retire", int_cpu, 1);
   endtask

   task automatic t_spurious();
      logic [7:0] v;
      do_reset();
      wr(0, 1, 8'h00);
      take_ack(v); chk("R11 spurious", v, 7);
      chk("R11 int", int_cpu, 0);
      irq_main = mline(4);
      tick();
      take_ack(v); chk("R11 no side effect", v, 4);
      irq_main = mline(1);
      wr(0, 1, 8'h02);
      tick();
      chk("R4 masked", int_cpu, 0);
   endtask

   task automatic t_cascade();
      logic [7:0] v, d;
      do_reset();
      wr(0, 1, 8'h00); wr(1, 1, 8'h00);
      irq_sub = 8'h20;
      tick(); tick();
      chk("R10 int", int_cpu, 1);
      rd(0, 0, d); chk("R10 R12 cascade line", d, 8'h04);
      take_ack(v); chk("R10 vec", v, 13);
      chk("R10 int off", int_cpu, 0);
      wr(1, 0, 8'hE5);
      chk("R10 main still busy", int_cpu, 0);
      wr(0, 0, 8'hE2);
      chk("R10 re-raise", int_cpu, 1);
      do_reset();
      wr(0, 1, 8'h00); wr(1, 1, 8'h00);
      irq_main = mline(1); irq_sub = 8'h01;
      tick(); tick();
      take_ack(v); chk("R10 main wins", v, 1);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_mask();
      t_reqread();
      t_rotate();
      t_eoi_idle();
      t_badcmd();
      t_spurious();
      t_cascade();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule